// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control section of a processor whose behaviour is held in a control store. A micro-program counter addresses a microcode ROM. Each word of that ROM carries two things. One is a two-bit sequencing code that chooses where the counter goes next. The other is a field of values for the datapath control points. The control points are a combinational read of the word at the current micro-address. The counter moves on every rising clock edge.

The next micro-address comes from one of a small set of sources: the following address, address zero (the fetch entry), or a jump target. The jump target is found by matching the current instruction opcode against a dispatch table of (opcode, target) pairs. A conditional form of the jump is also available, and it falls through to the following address when the condition flag is low.

The control field can be stored in either of two formats, chosen by a parameter. In the horizontal format every control point has its own bit. In the vertical format the three register-destination selects share one two-bit code, and that code is expanded to a one-hot group. The microcode image and the dispatch table are packed parameters, so each instance carries its own program.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the micro-PC becomes 0 at that edge, whatever the sequencing code, opcode or condition.
- R2: The sequencing code is held in bits [1:0] of each microcode word, and word i sits at `UCODE[i*WORD_W +: WORD_W]`. Code 00 moves the micro-PC to the current address plus one. From the highest address, 2**UA_W-1, it wraps to 0.
- R3: Code 10 moves the micro-PC to 0.
- R4: Code 01 moves the micro-PC to the target of the dispatch entry whose opcode equals `opcode`. Entry i is `DTABLE[i*(OP_W+UA_W) +: OP_W+UA_W]`, with the opcode in the upper OP_W bits and the target in the lower UA_W bits. When several entries match, the lowest index wins.
- R5: A dispatch (code 01, or code 11 with the condition set) on an opcode that matches no entry moves the micro-PC to 0.
- R6: Code 11 behaves as code 01 when `cond` is high. When `cond` is low it behaves as code 00.
- R7: In horizontal format (WORD_W = CTRL_W+2), `ctrl_pts` equals word bits [CTRL_W+1:2] of the word at the current micro-PC.
- R8: In vertical format (WORD_W = CTRL_W+1), word bits [3:2] hold a destination code that drives `ctrl_pts[2:0]`: 00 gives 000, 01 gives 001 (rt-ALU), 10 gives 010 (rd-ALU), 11 gives 100 (mem-ALU). Word bits [CTRL_W:4] drive `ctrl_pts[CTRL_W-1:3]`.
- R9: `ctrl_pts` follows the micro-PC in the same cycle, with no register between the ROM and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the micro-PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the micro-PC |
| opcode | input | OP_W | Opcode of the current instruction, used for dispatch |
| cond | input | 1 | Condition flag for the conditional dispatch code |
| ctrl_pts | output | CTRL_W | Datapath control-point values for the current micro-address |
| upc | output | UA_W | Current micro-PC |

## Verification
A wrong micro-PC shows up at `upc` at the first sample after the faulty edge. Because the control points are read combinationally from that address, `ctrl_pts` moves with it in the same cycle. A fault confined to the format decode shows up only on `ctrl_pts`, and it appears as soon as a word carrying the affected field is reached. A wrong dispatch priority or a wrong fall-through choice appears one edge after the word whose code selects it.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UC_BITS = 1024;
  localparam int DT_BITS = 256;

  typedef enum logic [1:0] {
    SEQ_NEXT  = 2'b00,
    SEQ_DISP  = 2'b01,
    SEQ_ZERO  = 2'b10,
    SEQ_CDISP = 2'b11
  } seq_e;

  // control points of the default program (12 points)
  localparam logic [11:0] CP_RT    = 12'h001;
  localparam logic [11:0] CP_RD    = 12'h002;
  localparam logic [11:0] CP_MEM   = 12'h004;
  localparam logic [11:0] CP_IRLD  = 12'h008;
  localparam logic [11:0] CP_PCINC = 12'h010;
  localparam logic [11:0] CP_IMM   = 12'h020;
  localparam logic [11:0] CP_SEXT  = 12'h040;
  localparam logic [11:0] CP_SUB   = 12'h080;
  localparam logic [11:0] CP_OR    = 12'h100;
  localparam logic [11:0] CP_MRD   = 12'h200;
  localparam logic [11:0] CP_MWR   = 12'h400;
  localparam logic [11:0] CP_BR    = 12'h800;

  function automatic logic [15:0] pack_word(bit vert, seq_e s, logic [11:0] cp);
    logic [1:0] code;
    if (!vert) return {2'b00, cp, s};
    code = cp[2] ? 2'b11 : (cp[1] ? 2'b10 : (cp[0] ? 2'b01 : 2'b00));
    return {3'b000, cp[11:3], code, s};
  endfunction

  // default microprogram for 32 words, 12 control points
  function automatic logic [UC_BITS-1:0] default_ucode(bit vert);
    logic [UC_BITS-1:0] img;
    logic [15:0]        prog [13];
    int                 ww;
    ww       = vert ? 13 : 14;
    img      = '0;
    prog[0]  = pack_word(vert, SEQ_NEXT, CP_IRLD | CP_PCINC);
    prog[1]  = pack_word(vert, SEQ_DISP, 12'h000);
    prog[2]  = pack_word(vert, SEQ_NEXT, 12'h000);
    prog[3]  = pack_word(vert, SEQ_ZERO, CP_RD);
    prog[4]  = pack_word(vert, SEQ_NEXT, CP_IMM | CP_OR);
    prog[5]  = pack_word(vert, SEQ_ZERO, CP_RT);
    prog[6]  = pack_word(vert, SEQ_NEXT, CP_IMM | CP_SEXT);
    prog[7]  = pack_word(vert, SEQ_NEXT, CP_IMM | CP_SEXT | CP_MRD);
    prog[8]  = pack_word(vert, SEQ_ZERO, CP_MEM);
    prog[9]  = pack_word(vert, SEQ_NEXT, CP_IMM | CP_SEXT);
    prog[10] = pack_word(vert, SEQ_ZERO, CP_IMM | CP_SEXT | CP_MWR);
    prog[11] = pack_word(vert, SEQ_NEXT, CP_SUB);
    prog[12] = pack_word(vert, SEQ_ZERO, CP_BR);
    for (int i = 0; i < 13; i++) begin
      for (int b = 0; b < ww; b++) begin
        img[i*ww + b] = prog[i][b];
      end
    end
    return img;
  endfunction

  // default dispatch table: {opcode[5:0], target[4:0]} per entry
  function automatic logic [DT_BITS-1:0] default_disp();
    logic [DT_BITS-1:0] img;
    img          = '0;
    img[0  +: 11] = {6'd0,  5'd2};
    img[11 +: 11] = {6'd1,  5'd4};
    img[22 +: 11] = {6'd2,  5'd6};
    img[33 +: 11] = {6'd3,  5'd9};
    img[44 +: 11] = {6'd4,  5'd11};
    img[55 +: 11] = {6'd63, 5'd0};
    return img;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store import useq_pkg::*; #(
  parameter int UA_W   = 5,
  parameter int WORD_W = 14,
  parameter logic [UC_BITS-1:0] UCODE = '0
) (
  input  logic [UA_W-1:0]   upc,
  output seq_e              seq_sel,
  output logic [WORD_W-3:0] field
);
  localparam int UDEPTH = 1 << UA_W;

  logic [WORD_W-1:0] rom [UDEPTH];
  logic [WORD_W-1:0] word;

  for (genvar i = 0; i < UDEPTH; i++) begin : g_word
    assign rom[i] = UCODE[i*WORD_W +: WORD_W];
  end

  assign word    = rom[upc];
  assign seq_sel = seq_e'(word[1:0]);
  assign field   = word[WORD_W-1:2];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch import useq_pkg::*; #(
  parameter int OP_W   = 6,
  parameter int UA_W   = 5,
  parameter int N_DISP = 6,
  parameter logic [DT_BITS-1:0] DTABLE = '0
) (
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] tgt,
  output logic            hit
);
  localparam int ENT_W = OP_W + UA_W;

  logic [OP_W-1:0] ent_op [N_DISP];
  logic [UA_W-1:0] ent_tg [N_DISP];
  logic [N_DISP-1:0] match;

  for (genvar i = 0; i < N_DISP; i++) begin : g_ent
    assign ent_op[i] = DTABLE[i*ENT_W + UA_W +: OP_W];
    assign ent_tg[i] = DTABLE[i*ENT_W +: UA_W];
    assign match[i]  = (opcode == ent_op[i]);
  end

  // scan from the top so the lowest matching index is left standing
  always_comb begin
    tgt = '0;
    hit = 1'b0;
    for (int i = N_DISP - 1; i >= 0; i--) begin
      if (match[i]) begin
        tgt = ent_tg[i];
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/useq_next.sv
module useq_next import useq_pkg::*; #(
  parameter int UA_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_e            seq_sel,
  input  logic            cond,
  input  logic [UA_W-1:0] disp_tgt,
  output logic [UA_W-1:0] upc
);
  logic [UA_W-1:0] nxt;

  always_comb begin
    unique case (seq_sel)
      SEQ_NEXT:  nxt = upc + 1'b1;
      SEQ_DISP:  nxt = disp_tgt;
      SEQ_ZERO:  nxt = '0;
      SEQ_CDISP: nxt = cond ? disp_tgt : upc + 1'b1;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= nxt;
  end
endmodule

// File: rtl/useq_expand.sv
module useq_expand #(
  parameter int CTRL_W   = 12,
  parameter bit VERTICAL = 1'b0,
  parameter int FIELD_W  = 12
) (
  input  logic [FIELD_W-1:0] field,
  output logic [CTRL_W-1:0]  ctrl_pts
);
  if (VERTICAL) begin : g_vert
    logic [2:0] dst;
    always_comb begin
      unique case (field[1:0])
        2'b01:   dst = 3'b001;
        2'b10:   dst = 3'b010;
        2'b11:   dst = 3'b100;
        default: dst = 3'b000;
      endcase
    end
    assign ctrl_pts = {field[FIELD_W-1:2], dst};
  end else begin : g_horiz
    assign ctrl_pts = field;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl import useq_pkg::*; #(
  parameter int UA_W     = 5,
  parameter int OP_W     = 6,
  parameter int CTRL_W   = 12,
  parameter int N_DISP   = 6,
  parameter bit VERTICAL = 1'b0,
  parameter logic [UC_BITS-1:0] UCODE  = default_ucode(VERTICAL),
  parameter logic [DT_BITS-1:0] DTABLE = default_disp()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              cond,
  output logic [CTRL_W-1:0] ctrl_pts,
  output logic [UA_W-1:0]   upc
);
  localparam int WORD_W  = VERTICAL ? CTRL_W + 1 : CTRL_W + 2;
  localparam int FIELD_W = WORD_W - 2;

  seq_e               seq_sel;
  logic [FIELD_W-1:0] field;
  logic [UA_W-1:0]    disp_tgt;
  logic               disp_hit;

  useq_store #(.UA_W(UA_W), .WORD_W(WORD_W), .UCODE(UCODE)) u_store (
    .upc(upc), .seq_sel(seq_sel), .field(field)
  );

  useq_dispatch #(.OP_W(OP_W), .UA_W(UA_W), .N_DISP(N_DISP), .DTABLE(DTABLE)) u_disp (
    .opcode(opcode), .tgt(disp_tgt), .hit(disp_hit)
  );

  useq_next #(.UA_W(UA_W)) u_next (
    .clk(clk), .rst(rst), .seq_sel(seq_sel), .cond(cond),
    .disp_tgt(disp_tgt), .upc(upc)
  );

  useq_expand #(.CTRL_W(CTRL_W), .VERTICAL(VERTICAL), .FIELD_W(FIELD_W)) u_exp (
    .field(field), .ctrl_pts(ctrl_pts)
  );
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk import useq_pkg::*; #(
  parameter int UA_W     = 5,
  parameter int CTRL_W   = 12,
  parameter bit VERTICAL = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              cond,
  input seq_e              seq_sel,
  input logic [UA_W-1:0]   upc,
  input logic [UA_W-1:0]   disp_tgt,
  input logic              disp_hit,
  input logic [CTRL_W-1:0] ctrl_pts
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (upc == '0));

  assert_seq_next_R2: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEQ_NEXT) |=> (upc == UA_W'($past(upc) + 1'b1)));

  assert_seq_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEQ_ZERO) |=> (upc == '0));

  assert_dispatch_R4: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEQ_DISP) |=> (upc == $past(disp_tgt)));

  assert_unmapped_R5: assert property (@(posedge clk) disable iff (rst)
    !disp_hit |-> (disp_tgt == '0));

  assert_cond_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEQ_CDISP && cond) |=> (upc == $past(disp_tgt)));

  assert_cond_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEQ_CDISP && !cond) |=> (upc == UA_W'($past(upc) + 1'b1)));

  if (VERTICAL) begin : g_vchk
    assert_dest_onehot_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ctrl_pts[2:0]));
  end
endmodule

bind useq_ctrl useq_ctrl_chk #(.UA_W(UA_W), .CTRL_W(CTRL_W), .VERTICAL(VERTICAL)) u_chk (
  .clk(clk), .rst(rst), .cond(cond), .seq_sel(seq_sel), .upc(upc),
  .disp_tgt(disp_tgt), .disp_hit(disp_hit), .ctrl_pts(ctrl_pts)
);

// File: tb/tb_useq_ctrl.sv
`timescale 1ns/1ps
module tb_useq_ctrl;
  localparam int UA_W = 5;
  localparam int OP_W = 6;
  localparam int CW   = 12;
  localparam int ND   = 6;

  localparam int DOP [ND] = '{5, 9, 5, 33, 17, 60};
  localparam int DTG [ND] = '{12, 20, 3, 31, 1, 7};

  function automatic logic [1023:0] mk_uc(bit vert);
    logic [1023:0] img;
    logic [31:0]   s;
    logic [15:0]   w;
    int            ww;
    ww  = vert ? 13 : 14;
    img = '0;
    s   = vert ? 32'h9e37_79b9 : 32'h1234_5678;
    for (int i = 0; i < 32; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      w = s[31:16];
      if (i == 0)  w[1:0] = 2'b01;
      if (i == 1)  w[1:0] = 2'b11;
      if (i == 31) w[1:0] = 2'b00;
      for (int b = 0; b < ww; b++) img[i*ww + b] = w[b];
    end
    return img;
  endfunction

  function automatic logic [255:0] mk_dt();
    logic [255:0] img;
    img = '0;
    for (int i = 0; i < ND; i++) img[i*11 +: 11] = {6'(DOP[i]), 5'(DTG[i])};
    return img;
  endfunction

  localparam logic [1023:0] UC_H = mk_uc(1'b0);
  localparam logic [1023:0] UC_V = mk_uc(1'b1);
  localparam logic [255:0]  DT   = mk_dt();

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [OP_W-1:0] opcode = '0;
  logic            cond = 1'b0;
  logic [CW-1:0]   ctrl_h, ctrl_v;
  logic [UA_W-1:0] upc_h, upc_v;

  int total = 0;
  int bad   = 0;
  logic [UA_W-1:0] mh = '0, mv = '0;

  always #2.5 clk = ~clk;

  useq_ctrl #(.UA_W(UA_W), .OP_W(OP_W), .CTRL_W(CW), .N_DISP(ND), .VERTICAL(1'b0),
              .UCODE(UC_H), .DTABLE(DT)) dut (
    .clk(clk), .rst(rst), .opcode(opcode), .cond(cond), .ctrl_pts(ctrl_h), .upc(upc_h));

  useq_ctrl #(.UA_W(UA_W), .OP_W(OP_W), .CTRL_W(CW), .N_DISP(ND), .VERTICAL(1'b1),
              .UCODE(UC_V), .DTABLE(DT)) dut_v (
    .clk(clk), .rst(rst), .opcode(opcode), .cond(cond), .ctrl_pts(ctrl_v), .upc(upc_v));

  function automatic logic [15:0] word_of(bit vert, logic [4:0] a);
    logic [15:0] w;
    int ww;
    ww = vert ? 13 : 14;
    w  = '0;
    for (int b = 0; b < ww; b++) w[b] = vert ? UC_V[int'(a)*ww + b] : UC_H[int'(a)*ww + b];
    return w;
  endfunction

  function automatic logic [4:0] look(logic [5:0] op, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < ND; i++) begin
      if (!hit && op == 6'(DOP[i])) begin
        hit = 1'b1;
        return 5'(DTG[i]);
      end
    end
    return 5'd0;
  endfunction

  // expected successor and the requirement it exercises
  function automatic logic [4:0] nxt(bit vert, logic [4:0] a, logic [5:0] op, logic c,
                                     output string tag);
    logic [1:0] s;
    bit hit;
    logic [4:0] t;
    s = word_of(vert, a)[1:0];
    t = look(op, hit);
    case (s)
      2'b00: begin tag = "R2"; return a + 5'd1; end
      2'b10: begin tag = "R3"; return 5'd0; end
      2'b01: begin tag = hit ? "R4" : "R5"; return t; end
      default: begin
        if (c) begin tag = hit ? "R6 R4" : "R6 R5"; return t; end
        tag = "R6"; return a + 5'd1;
      end
    endcase
  endfunction

  function automatic logic [11:0] exp_ctrl(bit vert, logic [4:0] a);
    logic [15:0] w;
    logic [2:0]  d;
    w = word_of(vert, a);
    if (!vert) return w[13:2];
    case (w[3:2])
      2'b01:   d = 3'b001;
      2'b10:   d = 3'b010;
      2'b11:   d = 3'b100;
      default: d = 3'b000;
    endcase
    return {w[12:4], d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(logic [5:0] op, logic c, logic r);
    logic [4:0] nh, nv;
    string th, tv;
    opcode = op; cond = c; rst = r;
    if (r) begin
      nh = 5'd0; nv = 5'd0; th = "R1"; tv = "R1";
    end else begin
      nh = nxt(1'b0, mh, op, c, th);
      nv = nxt(1'b1, mv, op, c, tv);
    end
    @(posedge clk);
    @(negedge clk);
    mh = nh; mv = nv;
    chk({th, " upc horizontal"}, 32'(upc_h), 32'(mh));
    chk({tv, " upc vertical"},   32'(upc_v), 32'(mv));
    chk("R7 R9 ctrl horizontal", 32'(ctrl_h), 32'(exp_ctrl(1'b0, mh)));
    chk("R8 R9 ctrl vertical",   32'(ctrl_v), 32'(exp_ctrl(1'b1, mv)));
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step(6'd0, 1'b0, 1'b1);              // R1 reset state
    step(6'd9, 1'b1, 1'b1);
    step(6'd33, 1'b0, 1'b0);             // R4 dispatch to top word
    step(6'd0, 1'b0, 1'b0);              // R2 wrap from top word to 0
    step(6'd5, 1'b0, 1'b0);              // R4 duplicate opcode, lowest index
    step(6'd0, 1'b0, 1'b1);
    step(6'd42, 1'b0, 1'b0);             // R5 unmapped opcode
    step(6'd17, 1'b0, 1'b0);             // to word 1 (conditional code)
    step(6'd9, 1'b1, 1'b0);              // R6 taken
    step(6'd0, 1'b0, 1'b1);
    step(6'd17, 1'b0, 1'b0);
    step(6'd9, 1'b0, 1'b0);              // R6 fall through
    step(6'd0, 1'b0, 1'b1);
    step(6'd17, 1'b0, 1'b0);
    step(6'd50, 1'b1, 1'b0);             // R6 taken on unmapped opcode, R5
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] op;
      if ($urandom_range(9) < 7) op = 6'(DOP[$urandom_range(ND - 1)]);
      else                       op = 6'($urandom);
      step(op, 1'($urandom), ($urandom_range(63) == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule